// File: doc/BRIEF.md
# Smart Card Contact Activation Sequencer

This block orders the card-side contacts of a smart card slot around supply ramp-up and ramp-down. When the host raises the enable request, the block turns on the card supply. It keeps reset, I/O and the card clock at zero until an external comparator reports that the supply is good. It then counts a programmable settling delay and frees the I/O line and card reset in the same cycle. The gated card clock follows on the second rising edge of the clock source.

When enable is lowered, or the supply collapses after it was good, the block shuts down in a fixed order. Card reset falls at once. The card clock runs for two more source cycles and stops at a falling edge. The I/O line then goes low, and the supply is switched off. A one-cycle done pulse closes the sequence.

The block runs on a single system clock. The card clock source is a free-running level, synchronous to that clock, and the block re-times it through a gate that only opens or closes while the source is low.

Top module: `scs_activation_seq`

## Requirements
- R1: While the synchronous active-high reset is applied, and after it is released with enable low, card_clk_o, card_rst_o, io_rel_o, vcc_en_o, active_o and done_o are all 0.
- R2: A 0-to-1 change of en_i sampled at a clock edge sets vcc_en_o at that edge. From then on, io_rel_o, card_rst_o and card_clk_o stay 0 for as long as vgood_i has not yet been sampled high.
- R3: io_rel_o and card_rst_o rise at the same edge. That edge is the DELAY_CYC-th clock edge after the edge that first samples vgood_i high, and the card clock is still 0 when they rise.
- R4: card_clk_o first goes high at the edge that samples the second 0-to-1 change of cclk_src_i after io_rel_o went high, and active_o is 1 by then.
- R5: While the clock gate is open, card_clk_o equals the value of cclk_src_i sampled at the previous edge. card_clk_o only rises after a source rise and only falls after a source fall, so no pulse is shortened.
- R6: When en_i is sampled low while the card is active, card_rst_o and active_o are 0 from that same edge, and io_rel_o stays 1.
- R7: After card reset drops, card_clk_o keeps following the source until the STOP_CYC-th (default second) source falling edge, and stays 0 from that edge on.
- R8: io_rel_o falls one clock after the card clock stops, and vcc_en_o falls one clock after io_rel_o.
- R9: If enable drops before the card clock was released (supply ramp or settling delay), no clock pulse appears. vcc_en_o falls at the third edge after the one that samples en_i low.
- R10: Loss of vgood_i during the settling delay, the release phase or the active phase starts the same shutdown sequence as a low enable.
- R11: Activation starts only on a rising edge of en_i. Enable held high after a shutdown does not switch the supply on again.
- R12: done_o is a single-cycle pulse, raised in the cycle in which vcc_en_o falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Activation request; rising edge starts, low level shuts down |
| vgood_i | input | 1 | Card supply at nominal level, from external comparator |
| cclk_src_i | input | 1 | Free-running card clock source, synchronous to clk |
| card_clk_o | output | 1 | Gated, re-timed card clock |
| card_rst_o | output | 1 | Card reset contact level |
| io_rel_o | output | 1 | I/O line release (0 forces the line low) |
| vcc_en_o | output | 1 | Card supply enable |
| active_o | output | 1 | Card clock released, card in session |
| done_o | output | 1 | One-cycle pulse at the end of shutdown |

## Verification
A full activation is run with the supply-good input held low for a while. This tells a design that waits for the supply apart from one that releases contacts early, and it measures the settling delay to the exact edge. The clock release and the stop are checked against a count of source rising and falling edges kept by the bench, which catches release or stop one source cycle off. Three shutdown paths are compared: enable low from active, enable low during ramp or delay, and supply loss. Together they separate the full clock-stop path from the skipped one and show that a held enable does not re-arm the block.

// File: rtl/scs_pkg.sv
`timescale 1ns/1ps
package scs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RAMP,
        ST_WAIT,
        ST_REL,
        ST_ACT,
        ST_STOP,
        ST_IOOFF,
        ST_PWROFF
    } scs_state_e;
endpackage

// File: rtl/scs_edge_det.sv
`timescale 1ns/1ps
module scs_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic sig_i,
    output logic rise_o,
    output logic fall_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = sig_i;
        rise_o = sig_i & ~prev_q;
        fall_o = ~sig_i & prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= prev_d;
    end
endmodule

// File: rtl/scs_clk_gate.sv
`timescale 1ns/1ps
module scs_clk_gate (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic open_i,
    input  logic close_i,
    output logic gate_o,
    output logic clk_o
);
    typedef struct packed {
        logic gate;
        logic out;
    } gate_t;

    gate_t d, q;

    always_comb begin
        d = q;
        // gate state may only change while the source is low
        if (!src_i) begin
            if (open_i)       d.gate = 1'b1;
            else if (close_i) d.gate = 1'b0;
        end
        d.out = d.gate & src_i;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign gate_o = q.gate;
    assign clk_o  = q.out;
endmodule

// File: rtl/scs_seq_fsm.sv
`timescale 1ns/1ps
module scs_seq_fsm
    import scs_pkg::*;
#(
    parameter int DELAY_CYC = 225000,
    parameter int STOP_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic vgood_i,
    input  logic src_i,
    input  logic rise_i,
    input  logic fall_i,
    input  logic gate_i,
    output logic open_o,
    output logic close_o,
    output logic crst_o,
    output logic io_o,
    output logic vcc_o,
    output logic act_o,
    output logic done_o
);
    localparam int DCW = $clog2(DELAY_CYC + 1);
    localparam int ECW = $clog2(STOP_CYC + 1);
    localparam logic [DCW-1:0] DLY_LAST  = DCW'(DELAY_CYC - 1);
    localparam logic [ECW-1:0] STOP_LAST = ECW'(STOP_CYC - 1);

    typedef struct packed {
        scs_state_e     state;
        logic           en_prev;
        logic [DCW-1:0] dly;
        logic [ECW-1:0] ecnt;
        logic           crst;
        logic           io;
        logic           vcc;
        logic           done;
    } fsm_t;

    fsm_t d, q;
    logic supply_lost;

    always_comb begin
        d         = q;
        d.en_prev = en_i;
        d.done    = 1'b0;
        open_o    = 1'b0;
        close_o   = 1'b0;
        supply_lost = ~vgood_i;
        case (q.state)
            ST_IDLE: begin
                if (en_i && !q.en_prev) begin
                    d.vcc   = 1'b1;
                    d.state = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (!en_i) begin
                    d.state = ST_STOP;
                    d.crst  = 1'b0;
                    d.ecnt  = '0;
                end else if (vgood_i) begin
                    d.state = ST_WAIT;
                    d.dly   = '0;
                end
            end
            ST_WAIT: begin
                if (!en_i || supply_lost) begin
                    d.state = ST_STOP;
                    d.crst  = 1'b0;
                    d.ecnt  = '0;
                end else if (q.dly == DLY_LAST) begin
                    d.state = ST_REL;
                    d.io    = 1'b1;
                    d.crst  = 1'b1;
                    d.ecnt  = '0;
                end else begin
                    d.dly = q.dly + DCW'(1);
                end
            end
            ST_REL: begin
                if (!en_i || supply_lost) begin
                    d.state = ST_STOP;
                    d.crst  = 1'b0;
                    d.ecnt  = '0;
                end else begin
                    if (rise_i && q.ecnt == '0) d.ecnt = ECW'(1);
                    // open during the low phase ahead of the second rise
                    if (q.ecnt != '0 && !src_i) begin
                        open_o  = 1'b1;
                        d.state = ST_ACT;
                    end
                end
            end
            ST_ACT: begin
                if (!en_i || supply_lost) begin
                    d.state = ST_STOP;
                    d.crst  = 1'b0;
                    d.ecnt  = '0;
                end
            end
            ST_STOP: begin
                if (!gate_i) begin
                    d.state = ST_IOOFF;
                end else if (fall_i) begin
                    if (q.ecnt == STOP_LAST) begin
                        close_o = 1'b1;
                        d.state = ST_IOOFF;
                    end else begin
                        d.ecnt = q.ecnt + ECW'(1);
                    end
                end
            end
            ST_IOOFF: begin
                d.io    = 1'b0;
                d.state = ST_PWROFF;
            end
            ST_PWROFF: begin
                d.vcc   = 1'b0;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign crst_o = q.crst;
    assign io_o   = q.io;
    assign vcc_o  = q.vcc;
    assign act_o  = (q.state == ST_ACT);
    assign done_o = q.done;
endmodule

// File: rtl/scs_activation_seq.sv
`timescale 1ns/1ps
module scs_activation_seq #(
    parameter int DELAY_CYC = 225000,
    parameter int STOP_CYC  = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    input  logic vgood_i,
    input  logic cclk_src_i,
    output logic card_clk_o,
    output logic card_rst_o,
    output logic io_rel_o,
    output logic vcc_en_o,
    output logic active_o,
    output logic done_o
);
    logic src_rise, src_fall;
    logic gate_open, gate_close, gate_on;

    scs_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (cclk_src_i),
        .rise_o (src_rise),
        .fall_o (src_fall)
    );

    scs_seq_fsm #(
        .DELAY_CYC (DELAY_CYC),
        .STOP_CYC  (STOP_CYC)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en_i    (en_i),
        .vgood_i (vgood_i),
        .src_i   (cclk_src_i),
        .rise_i  (src_rise),
        .fall_i  (src_fall),
        .gate_i  (gate_on),
        .open_o  (gate_open),
        .close_o (gate_close),
        .crst_o  (card_rst_o),
        .io_o    (io_rel_o),
        .vcc_o   (vcc_en_o),
        .act_o   (active_o),
        .done_o  (done_o)
    );

    scs_clk_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .src_i   (cclk_src_i),
        .open_i  (gate_open),
        .close_i (gate_close),
        .gate_o  (gate_on),
        .clk_o   (card_clk_o)
    );
endmodule

// File: rtl/scs_activation_seq_chk.sv
`timescale 1ns/1ps
module scs_activation_seq_chk (
    input logic clk,
    input logic rst,
    input logic en_i,
    input logic cclk_src_i,
    input logic card_clk_o,
    input logic card_rst_o,
    input logic io_rel_o,
    input logic vcc_en_o,
    input logic active_o,
    input logic done_o
);
    // R2
    io_needs_vcc_chk: assert property (@(posedge clk) disable iff (rst)
        io_rel_o |-> vcc_en_o);

    // R3
    rst_with_io_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(io_rel_o) |-> $rose(card_rst_o) && !card_clk_o);

    // R4
    clk_after_rel_chk: assert property (@(posedge clk) disable iff (rst)
        card_clk_o |-> io_rel_o && vcc_en_o);

    // R5
    clk_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(card_clk_o) |-> $past(cclk_src_i) && !$past(cclk_src_i, 2));

    // R5
    clk_fall_src_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(card_clk_o) |-> !$past(cclk_src_i) && $past(cclk_src_i, 2));

    // R6
    rst_drop_chk: assert property (@(posedge clk) disable iff (rst)
        active_o && !en_i |=> !card_rst_o && !active_o);

    // R8
    pwr_last_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(vcc_en_o) |-> done_o && !io_rel_o && !card_rst_o && !card_clk_o);

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

bind scs_activation_seq scs_activation_seq_chk u_chk (.*);

// File: tb/sim_scs_activation_seq.sv
`timescale 1ns/1ps
module sim_scs_activation_seq;
    localparam int DLY  = 20;
    localparam int STOP = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0;
    logic vgood = 1'b0;
    logic src = 1'b0;
    logic card_clk, card_rst, io_rel, vcc_en, active, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic sp = 1'b0;
    logic rise_nx = 1'b0;
    logic fall_nx = 1'b0;

    always #2 clk = ~clk;

    scs_activation_seq #(.DELAY_CYC(DLY), .STOP_CYC(STOP)) u0 (
        .clk(clk), .rst(rst), .en_i(en), .vgood_i(vgood), .cclk_src_i(src),
        .card_clk_o(card_clk), .card_rst_o(card_rst), .io_rel_o(io_rel),
        .vcc_en_o(vcc_en), .active_o(active), .done_o(done)
    );

    // outputs seen after this step come from the edge just passed;
    // rise_nx / fall_nx describe what the next edge samples on the source
    task automatic step();
        @(negedge clk);
        cyc++;
        sp = src;
        src = cyc[1];
        rise_nx = src & ~sp;
        fall_nx = ~src & sp;
    endtask

    task automatic chk(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk("R1", "outputs in reset", {card_clk, card_rst, io_rel, vcc_en, active, done}, 0);
        rst = 1'b0;
        repeat (3) step();
        chk("R1", "outputs after reset", {card_clk, card_rst, io_rel, vcc_en, active, done}, 0);
    endtask

    task automatic t_activate();
        int n;
        int rises;
        int seen;
        int mism;
        chk("R2", "supply before request", vcc_en, 0);
        en = 1'b1;
        step();
        chk("R2", "supply on request edge", vcc_en, 1);
        seen = 0;
        repeat (10) begin
            step();
            if (io_rel || card_rst || card_clk) seen++;
        end
        chk("R2", "contacts held during ramp", seen, 0);
        vgood = 1'b1;
        n = 0;
        while (!io_rel && n < DLY + 5) begin
            step();
            n++;
        end
        chk("R3", "edges until release", n, DLY + 1);
        chk("R3", "reset with io", card_rst, 1);
        chk("R3", "clock low at release", card_clk, 0);
        rises = rise_nx ? 1 : 0;
        n = 0;
        while (n < 40) begin
            step();
            n++;
            if (card_clk) break;
            if (rise_nx) rises++;
        end
        chk("R4", "source rises to first clock", rises, 2);
        chk("R4", "active at first clock", active, 1);
        mism = 0;
        repeat (16) begin
            step();
            if (card_clk != sp) mism++;
        end
        chk("R5", "clock copies source", mism, 0);
    endtask

    task automatic t_shutdown(string req);
        int f;
        int n;
        int pulse;
        int stray;
        logic fe;
        chk(req, "active before shutdown", active, 1);
        step();
        chk(req, "reset dropped", card_rst, 0);
        chk(req, "active dropped", active, 0);
        chk(req, "io still released", io_rel, 1);
        f = 0;
        n = 0;
        pulse = 0;
        while (f < STOP && n < 40) begin
            fe = fall_nx;
            step();
            n++;
            if (fe) f++;
            if (f == STOP - 1 && card_clk) pulse = 1;
        end
        chk("R7", "clock ran before last fall", pulse, 1);
        chk("R7", "clock low at stop", card_clk, 0);
        chk("R8", "io held at stop", io_rel, 1);
        stray = 0;
        step();
        if (card_clk) stray++;
        chk("R8", "io low after stop", io_rel, 0);
        chk("R8", "supply still on", vcc_en, 1);
        step();
        if (card_clk) stray++;
        chk("R8", "supply off", vcc_en, 0);
        chk("R12", "done raised with supply drop", done, 1);
        step();
        if (card_clk) stray++;
        chk("R12", "done single cycle", done, 0);
        chk("R7", "clock stays stopped", stray, 0);
    endtask

    task automatic t_abort(bit in_wait);
        int pulses;
        pulses = 0;
        en = 1'b1;
        step();
        if (in_wait) begin
            vgood = 1'b1;
            repeat (5) begin step(); if (card_clk) pulses++; end
        end else begin
            repeat (4) begin step(); if (card_clk) pulses++; end
        end
        en = 1'b0;
        step();
        if (card_clk) pulses++;
        step();
        if (card_clk) pulses++;
        step();
        if (card_clk) pulses++;
        chk("R9", "supply on two edges after abort", vcc_en, 1);
        step();
        chk("R9", "supply off third edge after abort", vcc_en, 0);
        chk("R9", "done on abort", done, 1);
        chk("R9", "no clock during abort", pulses + io_rel, 0);
        vgood = 1'b0;
        repeat (3) step();
    endtask

    task automatic t_supply_loss();
        int n;
        int on;
        vgood = 1'b0;
        step();
        chk("R10", "reset dropped on supply loss", card_rst, 0);
        n = 0;
        while (!done && n < 40) begin
            step();
            n++;
        end
        chk("R10", "shutdown completes on supply loss", done, 1);
        chk("R10", "io low at end", io_rel, 0);
        on = 0;
        repeat (12) begin
            step();
            if (vcc_en) on++;
        end
        chk("R11", "held enable does not restart", on, 0);
        en = 1'b0;
        repeat (2) step();
        chk("R11", "idle after enable drop", vcc_en, 0);
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: got 0 expected 1 (run ended)");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_activate();
        en = 1'b0;
        t_shutdown("R6");
        vgood = 1'b0;
        repeat (3) step();
        t_abort(1'b0);
        t_abort(1'b1);
        t_activate();
        t_supply_loss();
        t_activate();
        en = 1'b0;
        t_shutdown("R6");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule